// File: doc/BRIEF.md
# Plesiochronous Receive Elastic Buffer

This block sits on the receive side of a serial link whose two ends run from separate oscillators of the same nominal frequency. Symbols enter in the write (recovered) clock domain and leave in the local read clock domain. Neither clock is exact, so one side is always a little faster than the other. Over time the buffer would fill up or run dry.

The transmitter puts idle (comma) symbols into the stream. These carry no payload. The buffer steers its fill level back toward half by removing commas on the write side when occupancy is high. When occupancy is low, it repeats a comma on the read side. Data symbols cross untouched and in order.

The storage is a small dual-clock memory. Each side keeps a binary pointer and sends it to the other domain as Gray code through a two-flop synchroniser. From its own pointer and the synchronised remote pointer, each side computes its own estimate of the fill level.

Top module: `plesio_elastic_buf`

## Requirements
- R1: After both resets, `rd_valid`, `rd_comma`, `ovf_flag` and `udf_flag` are all low.
- R2: Every data symbol (`wr_comma` low) accepted by the write side comes out on `rd_sym` exactly once and in write order, with `rd_comma` low, as long as no overflow occurs.
- R3: A comma presented while the write-side fill estimate is above `HI_TH` (default 12) is discarded and not stored, so fewer commas leave than arrive when the read clock is slower.
- R4: When the read-side fill estimate is non-zero and below `LO_TH` (default 4) and the entry at the read head is a comma, the reader outputs that comma and keeps its read pointer. The comma repeats each cycle until the fill reaches `LO_TH`, so more commas leave than arrive when the read clock is faster.
- R5: After reset, `rd_valid` stays low until the read-side fill estimate has first reached `DEPTH/2` (default 8). Reading starts on the cycle after that.
- R6: `ovf_flag` is set when a data symbol is presented while the write-side fill estimate equals `DEPTH`. The flag stays high until write reset.
- R7: Once reading has started, a read cycle that finds the read-side fill estimate at zero drives `rd_valid` low on the next cycle and sets `udf_flag`. The flag stays high until read reset.
- R8: Every output with `rd_valid` and `rd_comma` high carries the comma's symbol value on `rd_sym` exactly as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (recovered) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | A symbol is presented this write cycle |
| wr_sym | input | SYM_W | Incoming symbol |
| wr_comma | input | 1 | High when the incoming symbol is an idle comma |
| rd_clk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | A symbol is on `rd_sym` this read cycle |
| rd_sym | output | SYM_W | Outgoing symbol |
| rd_comma | output | 1 | Outgoing symbol is a comma |
| ovf_flag | output | 1 | Sticky overflow, write domain |
| udf_flag | output | 1 | Sticky underflow, read domain |

## Verification
The assertions assume two things. First, both resets are held together for at least a few cycles of each clock. Second, the upstream source never changes the write inputs outside its own clock edge.

The bench drives every write input on the falling edge of `wr_clk` and asserts and releases both resets together. It runs the write stream at 250 MHz with the read clock set slower, faster or far slower, which forces deletion, insertion or overflow. It ends each random stream with data symbols, so a trailing comma cannot hold the read head indefinitely.

// File: rtl/eb_pkg.sv
package eb_pkg;

    // Widest pointer the Gray helpers handle.
    localparam int EB_PTR_MAXW = 16;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,   // not yet primed
        RD_POP    = 2'd1,   // emit head and advance
        RD_HOLD   = 2'd2,   // emit head comma, keep pointer
        RD_STARVE = 2'd3    // nothing available
    } rd_act_e;

    function automatic logic [EB_PTR_MAXW-1:0] bin2gray(input logic [EB_PTR_MAXW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [EB_PTR_MAXW-1:0] gray2bin(input logic [EB_PTR_MAXW-1:0] g);
        logic [EB_PTR_MAXW-1:0] b;
        b[EB_PTR_MAXW-1] = g[EB_PTR_MAXW-1];
        for (int i = EB_PTR_MAXW-2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/eb_sync2.sv
module eb_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/eb_store.sv
module eb_store #(
    parameter int DEPTH = 16,
    parameter int W     = 11,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eb_wr_ctl.sv
module eb_wr_ctl import eb_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int HI_TH = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          wr_comma,
    input  logic [PW-1:0] rgray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] fill,
    output logic          ovf
);
    localparam logic [PW-1:0] HI_V   = PW'(HI_TH);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

    logic [PW-1:0] wptr, wptr_nx, rptr_b;
    logic          full, drop;

    assign rptr_b  = PW'(gray2bin(EB_PTR_MAXW'(rgray_sync)));
    assign fill    = wptr - rptr_b;
    assign full    = (fill == FULL_V);
    assign drop    = wr_comma && (fill > HI_V);
    assign we      = wr_valid && !drop && !full;
    assign wptr_nx = wptr + PW'(we);
    assign waddr   = wptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
            ovf   <= 1'b0;
        end else begin
            wptr  <= wptr_nx;
            wgray <= PW'(bin2gray(EB_PTR_MAXW'(wptr_nx)));
            if (wr_valid && !drop && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/eb_rd_ctl.sv
module eb_rd_ctl import eb_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int LO_TH = 4,
    parameter int SYM_W = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    wgray_sync,
    input  logic             head_comma,
    input  logic [SYM_W-1:0] head_sym,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [PW-1:0]    fill,
    output logic             started,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym,
    output logic             out_comma,
    output logic             udf
);
    localparam logic [PW-1:0] LO_V   = PW'(LO_TH);
    localparam logic [PW-1:0] HALF_V = PW'(DEPTH / 2);

    logic [PW-1:0] rptr, rptr_nx, wptr_b;
    rd_act_e       act;
    logic          emit;

    assign wptr_b = PW'(gray2bin(EB_PTR_MAXW'(wgray_sync)));
    assign fill   = wptr_b - rptr;
    assign raddr  = rptr[AW-1:0];

    always_comb begin
        act = RD_IDLE;
        if (started) begin
            if (fill == '0)                     act = RD_STARVE;
            else if (head_comma && fill < LO_V) act = RD_HOLD;
            else                                act = RD_POP;
        end
    end

    assign emit    = (act == RD_POP) || (act == RD_HOLD);
    assign rptr_nx = rptr + PW'(act == RD_POP);

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr      <= '0;
            rgray     <= '0;
            started   <= 1'b0;
            out_valid <= 1'b0;
            out_sym   <= '0;
            out_comma <= 1'b0;
            udf       <= 1'b0;
        end else begin
            rptr      <= rptr_nx;
            rgray     <= PW'(bin2gray(EB_PTR_MAXW'(rptr_nx)));
            if (!started && fill >= HALF_V) started <= 1'b1;
            out_valid <= emit;
            out_sym   <= head_sym;
            out_comma <= emit && head_comma;
            if (act == RD_STARVE) udf <= 1'b1;
        end
    end
endmodule

// File: rtl/plesio_elastic_buf.sv
module plesio_elastic_buf #(
    parameter int SYM_W = 10,
    parameter int DEPTH = 16,
    parameter int HI_TH = 12,
    parameter int LO_TH = 4
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_valid,
    input  logic [SYM_W-1:0] wr_sym,
    input  logic             wr_comma,
    input  logic             rd_clk,
    input  logic             rd_rst,
    output logic             rd_valid,
    output logic [SYM_W-1:0] rd_sym,
    output logic             rd_comma,
    output logic             ovf_flag,
    output logic             udf_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int EW = SYM_W + 1;

    logic          mem_we;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
    logic [PW-1:0] wr_fill, rd_fill;
    logic [EW-1:0] head_ent;
    logic          head_comma;
    logic          rd_started;

    assign head_comma = head_ent[SYM_W];

    eb_wr_ctl #(.DEPTH(DEPTH), .HI_TH(HI_TH)) u_wctl (
        .clk(wr_clk), .rst(wr_rst),
        .wr_valid(wr_valid), .wr_comma(wr_comma),
        .rgray_sync(rgray_ws),
        .we(mem_we), .waddr(wr_addr), .wgray(wgray),
        .fill(wr_fill), .ovf(ovf_flag)
    );

    eb_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .wclk(wr_clk), .we(mem_we), .waddr(wr_addr),
        .wdata({wr_comma, wr_sym}),
        .raddr(rd_addr), .rdata(head_ent)
    );

    eb_sync2 #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_rs)
    );

    eb_sync2 #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_ws)
    );

    eb_rd_ctl #(.DEPTH(DEPTH), .LO_TH(LO_TH), .SYM_W(SYM_W)) u_rctl (
        .clk(rd_clk), .rst(rd_rst),
        .wgray_sync(wgray_rs),
        .head_comma(head_comma), .head_sym(head_ent[SYM_W-1:0]),
        .raddr(rd_addr), .rgray(rgray), .fill(rd_fill),
        .started(rd_started),
        .out_valid(rd_valid), .out_sym(rd_sym), .out_comma(rd_comma),
        .udf(udf_flag)
    );
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
    parameter int DEPTH = 16,
    parameter int HI_TH = 12,
    parameter int LO_TH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          wr_valid,
    input logic          wr_comma,
    input logic          mem_we,
    input logic [PW-1:0] wr_fill,
    input logic          rd_started,
    input logic [PW-1:0] rd_fill,
    input logic          head_comma,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic          rd_comma,
    input logic          ovf_flag,
    input logic          udf_flag
);
    localparam logic [PW-1:0] HI_V   = PW'(HI_TH);
    localparam logic [PW-1:0] LO_V   = PW'(LO_TH);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

    p_keep_data_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_valid && !wr_comma && wr_fill != FULL_V) |-> mem_we);

    p_drop_comma_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_valid && wr_comma && wr_fill > HI_V) |-> !mem_we);

    p_hold_comma_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_started && rd_fill != '0 && rd_fill < LO_V && head_comma)
        |=> (rd_valid && rd_comma && $stable(rd_addr)));

    p_no_early_read_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_started |=> !rd_valid);

    p_fill_bound_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_fill <= FULL_V);

    p_ovf_sticky_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        ovf_flag |=> ovf_flag);

    p_starve_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_started && rd_fill == '0) |=> (!rd_valid && udf_flag));

    p_udf_sticky_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        udf_flag |=> udf_flag);
endmodule

bind plesio_elastic_buf eb_checker #(
    .DEPTH(DEPTH), .HI_TH(HI_TH), .LO_TH(LO_TH)
) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .wr_valid(wr_valid), .wr_comma(wr_comma), .mem_we(mem_we),
    .wr_fill(wr_fill), .rd_started(rd_started), .rd_fill(rd_fill),
    .head_comma(head_comma), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_comma(rd_comma),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
);

// File: tb/tb_plesio_elastic_buf.sv
`timescale 1ns/1ps
module tb_plesio_elastic_buf;
    localparam int          SW   = 10;
    localparam logic [9:0]  KSYM = 10'h3BC;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic          wr_valid = 1'b0, wr_comma = 1'b0;
    logic [SW-1:0] wr_sym = '0;
    logic          rd_valid, rd_comma, ovf_flag, udf_flag;
    logic [SW-1:0] rd_sym;

    real        rd_half = 2.0;
    int         checks = 0, fails = 0, ci = 0, co = 0;
    bit         sb_on = 1'b1, seen_valid = 1'b0;
    logic [9:0] exp_q [$];

    plesio_elastic_buf #(.SYM_W(SW)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid),
        .wr_sym(wr_sym), .wr_comma(wr_comma),
        .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_valid(rd_valid), .rd_sym(rd_sym), .rd_comma(rd_comma),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    always #2 wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Read-side scoreboard
    always @(negedge rd_clk) begin : mon
        logic [9:0] e;
        if (!rd_rst && rd_valid) begin
            seen_valid = 1'b1;
            if (rd_comma) begin
                co++;
                chk(rd_sym == KSYM, "R8", "comma symbol value", int'(rd_sym), int'(KSYM));
            end else if (sb_on) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected data symbol", int'(rd_sym), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(rd_sym == e, "R2", "data order", int'(rd_sym), int'(e));
                end
            end
        end
    end

    task automatic put(input bit c, input logic [9:0] v);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_comma = c;
        wr_sym   = c ? KSYM : v;
        if (c) ci++;
        else if (sb_on) exp_q.push_back(v);
    endtask

    task automatic idle();
        @(negedge wr_clk);
        wr_valid = 1'b0;
        wr_comma = 1'b0;
    endtask

    task automatic rdwait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic do_reset();
        wr_valid = 1'b0;
        wr_comma = 1'b0;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (3) @(posedge rd_clk);
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        exp_q.delete();
        ci = 0;
        co = 0;
        seen_valid = 1'b0;
        @(negedge wr_clk);
        chk(!rd_valid && !rd_comma, "R1", "read outputs after reset", int'(rd_valid), 0);
        chk(!ovf_flag && !udf_flag, "R1", "flags after reset", int'({ovf_flag, udf_flag}), 0);
    endtask

    // Random stream with ~40% commas; last four symbols are data.
    task automatic stream(input int n);
        for (int i = 0; i < n; i++) begin
            bit c;
            c = (i < n - 4) && (($urandom % 10) < 4);
            put(c, 10'($urandom % 1024));
        end
        idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge wr_clk);
        fails++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED));

        // R1 and R5: priming threshold
        do_reset();
        for (int i = 0; i < 7; i++) put(1'b0, 10'(i + 1));
        idle();
        rdwait(30);
        chk(!seen_valid, "R5", "no output below half fill", int'(seen_valid), 0);
        put(1'b0, 10'd8);
        idle();
        rdwait(30);
        chk(seen_valid, "R5", "output after half fill", int'(seen_valid), 1);
        chk(exp_q.size() == 0, "R2", "primed symbols delivered", exp_q.size(), 0);

        // R4 / R7 directed: comma held at head while fill is low
        do_reset();
        for (int i = 0; i < 5; i++) put(1'b0, 10'(16 + i));
        put(1'b1, 10'd0);
        put(1'b0, 10'd40);
        put(1'b0, 10'd41);
        idle();
        rdwait(40);
        begin
            int c0;
            c0 = co;
            rdwait(20);
            chk(co - c0 >= 15, "R4", "comma repeated while fill low", co - c0, 15);
        end
        @(negedge rd_clk);
        chk(rd_valid && rd_comma, "R4", "held comma on output", int'({rd_valid, rd_comma}), 3);
        chk(!udf_flag, "R7", "no underflow while comma held", int'(udf_flag), 0);
        for (int i = 0; i < 3; i++) put(1'b0, 10'(50 + i));
        idle();
        rdwait(40);
        chk(exp_q.size() == 0, "R2", "data after held comma delivered", exp_q.size(), 0);
        chk(udf_flag, "R7", "underflow after draining", int'(udf_flag), 1);
        chk(!rd_valid, "R7", "no output while empty", int'(rd_valid), 0);
        for (int i = 0; i < 8; i++) put(1'b0, 10'(60 + i));
        idle();
        rdwait(40);
        chk(udf_flag, "R7", "underflow flag sticky", int'(udf_flag), 1);
        chk(exp_q.size() == 0, "R2", "data after underflow delivered", exp_q.size(), 0);

        // R3: read clock slower -> commas deleted
        rd_half = 2.2;
        do_reset();
        stream(2000);
        rdwait(100);
        chk(co < ci, "R3", "commas deleted on slow reader", co, ci);
        chk(!ovf_flag, "R6", "no overflow with comma deletion", int'(ovf_flag), 0);
        chk(exp_q.size() == 0, "R2", "slow reader data complete", exp_q.size(), 0);

        // R4: read clock faster -> commas inserted
        rd_half = 1.8;
        do_reset();
        stream(2000);
        rdwait(100);
        chk(co > ci, "R4", "commas inserted on fast reader", co, ci);
        chk(!ovf_flag, "R6", "no overflow on fast reader", int'(ovf_flag), 0);
        chk(exp_q.size() == 0, "R2", "fast reader data complete", exp_q.size(), 0);

        // R6: overflow with a very slow reader
        rd_half = 20.0;
        do_reset();
        sb_on = 1'b0;
        for (int i = 0; i < 24; i++) put(1'b0, 10'(i));
        idle();
        @(negedge wr_clk);
        chk(ovf_flag, "R6", "overflow on write while full", int'(ovf_flag), 1);
        repeat (50) @(negedge wr_clk);
        chk(ovf_flag, "R6", "overflow flag sticky", int'(ovf_flag), 1);

        rd_half = 2.0;
        do_reset();
        sb_on = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule